// File: doc/BRIEF.md
# Sinogram Tile Window Prefetcher

This block feeds one back-projection tile of 16 by 16 voxels, one voxel deep. For each projection angle it receives the detector coordinates of the tile's four projected corners. From them it computes where a fixed window of 24 detector columns by 4 detector rows should start. It then pulls that window out of external sinogram memory into a local buffer, one contiguous burst per window row. The window is deliberately wider than the tile's projected footprint, which always spans at most 4 rows and fewer than about 23 columns. Every angle therefore uses the same fetch shape, whatever the geometry.

Use alternates between two phases. A start pulse latches the corners and begins the fill. When the last word lands, `ready` rises, and the lanes of the tile read samples by local (column, row) offset through a registered lookup port. When all lanes are done, a done pulse releases the buffer so that the next angle can be fetched. A start pulse that arrives in any other phase is dropped. This keeps a refill from overwriting data that lanes still need.

Top module: `sinowin_prefetch`

## Requirements
- R1: During and straight after reset, `ready`, `burstReq`, `lkData` and `lkErr` are all zero.
- R2: On an accepted start, `originU` is set to the minimum of the four signed (two's complement) corner columns, clamped to the range 0 to COLS-24. `originV` is set to the minimum of the four corner rows, clamped to the range 0 to ROWS-4. When the window would cross the far edge, it is pushed back so that it ends on that edge.
- R3: A start pulse is accepted only in the idle phase. A start during the fill or the ready phase changes nothing, and the origin stays as it was.
- R4: The fill issues one burst request per window row, rows 0 to 3 in order. Each request is held until it is acknowledged. The request address is `baseAddr + (originV+row)*COLS + originU`, and only one burst is outstanding at a time.
- R5: After a burst is acknowledged, the next 24 accepted words (`wordValid` high) fill that row at columns 0 to 23, in arrival order. `wordValid` outside that receive window is ignored.
- R6: `ready` rises in the cycle after the 96th word is accepted. It holds until `lanesDone` and then falls. `burstReq` is never high while `ready` is high.
- R7: A lookup with `lkEn` high while `ready` is high and with `lkU` < 24 and `lkV` < 4 returns the stored word at column `lkU` of row `lkV` on `lkData` one cycle later, with `lkErr` low.
- R8: A lookup while `ready` is high with `lkU` >= 24 or `lkV` >= 4 returns `lkData` = 0 and `lkErr` = 1 one cycle later.
- R9: A lookup while `ready` is low, or a cycle with `lkEn` low, gives `lkData` = 0 and `lkErr` = 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fillStart | input | 1 | Start-of-angle pulse; latches the corners and begins the fill |
| cornersU | input | 4*COORD_W | Four signed corner columns, corner 0 in the low bits |
| cornersV | input | 4*COORD_W | Four signed corner rows, corner 0 in the low bits |
| baseAddr | input | ADDR_W | Word address of sample (0,0) of the current angle |
| burstReq | output | 1 | Burst read request for one window row |
| burstAddr | output | ADDR_W | First word address of the requested row |
| burstAck | input | 1 | Memory accepts the pending burst |
| wordValid | input | 1 | One returned sample is present |
| wordData | input | DATA_W | Returned sample |
| ready | output | 1 | Window buffer is full and may be read |
| lanesDone | input | 1 | All lanes have finished reading; releases the buffer |
| lkEn | input | 1 | Lookup request |
| lkU | input | LU_W | Local column offset |
| lkV | input | LV_W | Local row offset |
| lkData | output | DATA_W | Lookup result, one cycle after the request |
| lkErr | output | 1 | Lookup offset was out of range |
| originU | output | UW | Window start column |
| originV | output | VW | Window start row |

## Verification
The assertions assume that memory returns words only after it has acknowledged a burst, that it never returns more than the 24 words of that burst, and that `burstAck` is looked at only while a request is pending. The stimulus follows these rules. The memory model queues exactly 24 addresses per acknowledged request and presents words only from that queue, with random gaps and random acknowledge delays. The one exception is a deliberate burst of stray words in the idle phase. The corner sets are chosen to land the origin inside the range, below zero, and past the far edge, so the clamp is exercised in both directions.

// File: rtl/sinowin_pkg.sv
package sinowin_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_REQ   = 2'd1,
    PH_RECV  = 2'd2,
    PH_READY = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchOrigin;
    logic clearCount;
    logic storeWord;
    logic nextRow;
  } ctrl_strobes_t;

endpackage

// File: rtl/sinowin_ctrl.sv
module sinowin_ctrl
  import sinowin_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          fillStart,
  input  logic          burstAck,
  input  logic          wordValid,
  input  logic          lanesDone,
  input  logic          rowLast,
  input  logic          colLast,
  output ctrl_strobes_t strobes,
  output logic          burstReq,
  output logic          ready
);

  phase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strobes   = '0;
    unique case (phase)
      PH_IDLE: begin
        if (fillStart) begin
          strobes.latchOrigin = 1'b1;
          strobes.clearCount  = 1'b1;
          phaseNext           = PH_REQ;
        end
      end
      PH_REQ: begin
        if (burstAck) phaseNext = PH_RECV;
      end
      PH_RECV: begin
        if (wordValid) begin
          strobes.storeWord = 1'b1;
          if (colLast) begin
            if (rowLast) begin
              phaseNext = PH_READY;
            end else begin
              strobes.nextRow = 1'b1;
              phaseNext       = PH_REQ;
            end
          end
        end
      end
      PH_READY: begin
        if (lanesDone) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  assign burstReq = (phase == PH_REQ);
  assign ready    = (phase == PH_READY);

endmodule

// File: rtl/sinowin_dpath.sv
module sinowin_dpath
  import sinowin_pkg::*;
#(
  parameter int COLS    = 64,
  parameter int ROWS    = 32,
  parameter int WIN_W   = 24,
  parameter int WIN_H   = 4,
  parameter int COORD_W = 10,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NCORNER = 4,
  localparam int UW     = $clog2(COLS),
  localparam int VW     = $clog2(ROWS),
  localparam int LU_W   = $clog2(WIN_W) + 1,
  localparam int LV_W   = $clog2(WIN_H) + 1
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strobes_t              strobes,
  input  logic                       ready,
  input  logic [NCORNER*COORD_W-1:0] cornersU,
  input  logic [NCORNER*COORD_W-1:0] cornersV,
  input  logic [ADDR_W-1:0]          baseAddr,
  input  logic [DATA_W-1:0]          wordData,
  input  logic                       lkEn,
  input  logic [LU_W-1:0]            lkU,
  input  logic [LV_W-1:0]            lkV,
  output logic                       rowLast,
  output logic                       colLast,
  output logic [ADDR_W-1:0]          burstAddr,
  output logic [DATA_W-1:0]          lkData,
  output logic                       lkErr,
  output logic [UW-1:0]              originU,
  output logic [VW-1:0]              originV
);

  localparam int DEPTH = WIN_W * WIN_H;
  localparam int IW    = $clog2(DEPTH);
  localparam int RW    = $clog2(WIN_H);
  localparam int CW    = $clog2(WIN_W);
  localparam int MAXU  = COLS - WIN_W;
  localparam int MAXV  = ROWS - WIN_H;

  // corner unpacking
  logic signed [COORD_W-1:0] cu [NCORNER];
  logic signed [COORD_W-1:0] cv [NCORNER];

  for (genvar g = 0; g < NCORNER; g++) begin : g_corner
    assign cu[g] = cornersU[g*COORD_W +: COORD_W];
    assign cv[g] = cornersV[g*COORD_W +: COORD_W];
  end

  logic signed [COORD_W-1:0] minU, minV;
  logic [UW-1:0] clampU;
  logic [VW-1:0] clampV;

  always_comb begin
    minU = cu[0];
    minV = cv[0];
    for (int i = 1; i < NCORNER; i++) begin
      if (cu[i] < minU) minU = cu[i];
      if (cv[i] < minV) minV = cv[i];
    end
  end

  always_comb begin
    if (minU < 0)              clampU = '0;
    else if (int'(minU) > MAXU) clampU = UW'(MAXU);
    else                       clampU = UW'(minU);
    if (minV < 0)              clampV = '0;
    else if (int'(minV) > MAXV) clampV = VW'(MAXV);
    else                       clampV = VW'(minV);
  end

  logic [RW-1:0] rowCnt;
  logic [CW-1:0] colCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      originU <= '0;
      originV <= '0;
      rowCnt  <= '0;
      colCnt  <= '0;
    end else begin
      if (strobes.latchOrigin) begin
        originU <= clampU;
        originV <= clampV;
      end
      if (strobes.clearCount) begin
        rowCnt <= '0;
        colCnt <= '0;
      end else begin
        if (strobes.storeWord) colCnt <= colLast ? '0 : colCnt + 1'b1;
        if (strobes.nextRow)   rowCnt <= rowCnt + 1'b1;
      end
    end
  end

  assign rowLast = (rowCnt == RW'(WIN_H - 1));
  assign colLast = (colCnt == CW'(WIN_W - 1));

  assign burstAddr = baseAddr
                   + (ADDR_W'(originV) + ADDR_W'(rowCnt)) * ADDR_W'(COLS)
                   + ADDR_W'(originU);

  // window storage
  logic [DATA_W-1:0] winBuf [DEPTH];
  logic [IW-1:0]     wrIdx, rdIdx;
  logic              lkOut;

  assign wrIdx = IW'(rowCnt) * IW'(WIN_W) + IW'(colCnt);
  assign rdIdx = IW'(lkV) * IW'(WIN_W) + IW'(lkU);
  assign lkOut = (lkU >= LU_W'(WIN_W)) || (lkV >= LV_W'(WIN_H));

  always_ff @(posedge clk) begin
    if (strobes.storeWord) winBuf[wrIdx] <= wordData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkData <= '0;
      lkErr  <= 1'b0;
    end else if (lkEn && ready) begin
      if (lkOut) begin
        lkData <= '0;
        lkErr  <= 1'b1;
      end else begin
        lkData <= winBuf[rdIdx];
        lkErr  <= 1'b0;
      end
    end else begin
      lkData <= '0;
      lkErr  <= 1'b0;
    end
  end

endmodule

// File: rtl/sinowin_prefetch.sv
module sinowin_prefetch
  import sinowin_pkg::*;
#(
  parameter int COLS    = 64,
  parameter int ROWS    = 32,
  parameter int WIN_W   = 24,
  parameter int WIN_H   = 4,
  parameter int COORD_W = 10,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  localparam int NCORNER = 4,
  localparam int UW      = $clog2(COLS),
  localparam int VW      = $clog2(ROWS),
  localparam int LU_W    = $clog2(WIN_W) + 1,
  localparam int LV_W    = $clog2(WIN_H) + 1
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       fillStart,
  input  logic [NCORNER*COORD_W-1:0] cornersU,
  input  logic [NCORNER*COORD_W-1:0] cornersV,
  input  logic [ADDR_W-1:0]          baseAddr,
  output logic                       burstReq,
  output logic [ADDR_W-1:0]          burstAddr,
  input  logic                       burstAck,
  input  logic                       wordValid,
  input  logic [DATA_W-1:0]          wordData,
  output logic                       ready,
  input  logic                       lanesDone,
  input  logic                       lkEn,
  input  logic [LU_W-1:0]            lkU,
  input  logic [LV_W-1:0]            lkV,
  output logic [DATA_W-1:0]          lkData,
  output logic                       lkErr,
  output logic [UW-1:0]              originU,
  output logic [VW-1:0]              originV
);

  ctrl_strobes_t strobes;
  logic rowLast, colLast;

  sinowin_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fillStart (fillStart),
    .burstAck  (burstAck),
    .wordValid (wordValid),
    .lanesDone (lanesDone),
    .rowLast   (rowLast),
    .colLast   (colLast),
    .strobes   (strobes),
    .burstReq  (burstReq),
    .ready     (ready)
  );

  sinowin_dpath #(
    .COLS(COLS), .ROWS(ROWS), .WIN_W(WIN_W), .WIN_H(WIN_H),
    .COORD_W(COORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCORNER(NCORNER)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .ready     (ready),
    .cornersU  (cornersU),
    .cornersV  (cornersV),
    .baseAddr  (baseAddr),
    .wordData  (wordData),
    .lkEn      (lkEn),
    .lkU       (lkU),
    .lkV       (lkV),
    .rowLast   (rowLast),
    .colLast   (colLast),
    .burstAddr (burstAddr),
    .lkData    (lkData),
    .lkErr     (lkErr),
    .originU   (originU),
    .originV   (originV)
  );

endmodule

// File: rtl/sinowin_prefetch_chk.sv
module sinowin_prefetch_chk #(
  parameter int COLS   = 64,
  parameter int ROWS   = 32,
  parameter int WIN_W  = 24,
  parameter int WIN_H  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int UW     = 6,
  parameter int VW     = 5
)(
  input logic              clk,
  input logic              rstN,
  input logic              burstReq,
  input logic              burstAck,
  input logic [ADDR_W-1:0] burstAddr,
  input logic              wordValid,
  input logic              ready,
  input logic [DATA_W-1:0] lkData,
  input logic              lkErr,
  input logic [UW-1:0]     originU,
  input logic [VW-1:0]     originV
);

  // R2
  origin_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(originU) <= COLS - WIN_W) && (int'(originV) <= ROWS - WIN_H));

  // R3
  origin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> ($stable(originU) && $stable(originV)));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstReq && !burstAck) |=> (burstReq && $stable(burstAddr)));

  // R6
  no_req_when_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(burstReq && ready));

  // R6
  ready_after_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(wordValid));

  // R8
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkErr |-> (lkData == '0));

  // R9
  idle_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ready) |-> (!lkErr && lkData == '0));

endmodule

bind sinowin_prefetch sinowin_prefetch_chk #(
  .COLS(COLS), .ROWS(ROWS), .WIN_W(WIN_W), .WIN_H(WIN_H),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UW(UW), .VW(VW)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .burstReq  (burstReq),
  .burstAck  (burstAck),
  .burstAddr (burstAddr),
  .wordValid (wordValid),
  .ready     (ready),
  .lkData    (lkData),
  .lkErr     (lkErr),
  .originU   (originU),
  .originV   (originV)
);

// File: tb/test_sinowin_prefetch.sv
module test_sinowin_prefetch;

  localparam int COLS = 64, ROWS = 32, WW = 24, WH = 4, CWD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fillStart = 1'b0;
  logic [39:0] cornersU = '0, cornersV = '0;
  logic [15:0] baseAddr = 16'h1000;
  logic        burstReq;
  logic [15:0] burstAddr;
  logic        burstAck = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic        ready;
  logic        lanesDone = 1'b0;
  logic        lkEn = 1'b0;
  logic [5:0]  lkU = '0;
  logic [2:0]  lkV = '0;
  logic [15:0] lkData;
  logic        lkErr;
  logic [5:0]  originU;
  logic [4:0]  originV;

  always #4 clk = ~clk;

  sinowin_prefetch i_sinowin_prefetch (.*);

  int compared = 0, mismatched = 0, cycles = 0;
  bit cmpOn = 0, spurious = 0;

  // reference model state
  int mState = 0, mRow = 0, mCol = 0, mU0 = 0, mV0 = 0;
  int mBuf [96];
  int mLkData = 0, mLkErr = 0;
  string mLkTag = "R9";
  int memQ [$];

  function automatic int memf(int a);
    return (a * 37 + 11) & 16'hFFFF;
  endfunction

  function automatic int sx(logic [9:0] v);
    return int'($signed(v));
  endfunction

  function automatic int expAddr();
    return int'(baseAddr) + (mV0 + mRow) * COLS + mU0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mRow = 0; mCol = 0; mU0 = 0; mV0 = 0;
      mLkData = 0; mLkErr = 0; mLkTag = "R9";
    end else begin
      if (lkEn && mState == 3) begin
        if (lkU > 23 || lkV > 3) begin
          mLkData = 0; mLkErr = 1; mLkTag = "R8";
        end else begin
          mLkData = mBuf[lkV * WW + lkU]; mLkErr = 0; mLkTag = "R5/R7";
        end
      end else begin
        mLkData = 0; mLkErr = 0; mLkTag = "R9";
      end
      case (mState)
        0: if (fillStart) begin
             int mu, mv;
             mu = sx(cornersU[9:0]); mv = sx(cornersV[9:0]);
             for (int k = 1; k < 4; k++) begin
               if (sx(cornersU[k*CWD +: CWD]) < mu) mu = sx(cornersU[k*CWD +: CWD]);
               if (sx(cornersV[k*CWD +: CWD]) < mv) mv = sx(cornersV[k*CWD +: CWD]);
             end
             mU0 = (mu < 0) ? 0 : (mu > COLS - WW) ? COLS - WW : mu;
             mV0 = (mv < 0) ? 0 : (mv > ROWS - WH) ? ROWS - WH : mv;
             mRow = 0; mCol = 0; mState = 1;
           end
        1: if (burstAck) begin
             for (int k = 0; k < WW; k++) memQ.push_back(expAddr() + k);
             mState = 2;
           end
        2: if (wordValid) begin
             mBuf[mRow * WW + mCol] = int'(wordData);
             if (mCol == WW - 1) begin
               mCol = 0;
               if (mRow == WH - 1) mState = 3;
               else begin mRow++; mState = 1; end
             end else mCol++;
           end
        default: if (lanesDone) mState = 0;
      endcase
      if (wordValid && !spurious && memQ.size() > 0) void'(memQ.pop_front());
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R6 ready", int'(ready), int'(mState == 3));
      chk("R4 burstReq", int'(burstReq), int'(mState == 1));
      if (mState == 1) chk("R4 burstAddr", int'(burstAddr), expAddr());
      chk("R2/R3 originU", int'(originU), mU0);
      chk("R2/R3 originV", int'(originV), mV0);
      chk({mLkTag, " lkData"}, int'(lkData), mLkData);
      chk({mLkTag, " lkErr"}, int'(lkErr), mLkErr);
    end
  end

  // memory responder
  always @(negedge clk) begin
    burstAck = ($urandom_range(0, 2) != 0);
    if (spurious) begin
      wordValid = 1'b1;
      wordData  = 16'hDEAD;
    end else if (memQ.size() > 0) begin
      wordValid = ($urandom_range(0, 3) != 0);
      wordData  = 16'(memf(memQ[0]));
    end else begin
      wordValid = 1'b0;
      wordData  = '0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [39:0] pack4(int a, int b, int c, int d);
    return {10'(d), 10'(c), 10'(b), 10'(a)};
  endfunction

  task automatic fill(logic [39:0] u, logic [39:0] v, bit interfere);
    int guard = 0;
    @(negedge clk);
    cornersU = u; cornersV = v; fillStart = 1'b1;
    @(negedge clk);
    fillStart = 1'b0;
    if (interfere) begin
      // R3: start during fill with corners that would move the origin
      repeat (5) @(negedge clk);
      cornersU = pack4(50, 60, 55, 58); cornersV = pack4(29, 30, 31, 29);
      fillStart = 1'b1;
      // R9: lookups before the buffer is ready
      lkEn = 1'b1; lkU = 6'd2; lkV = 3'd1;
      @(negedge clk);
      fillStart = 1'b0;
      repeat (3) @(negedge clk);
      lkEn = 1'b0;
    end
    while (!ready && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    // R3: start in the ready phase is ignored too
    cornersU = pack4(-9, -9, -9, -9); cornersV = pack4(-9, -9, -9, -9);
    fillStart = 1'b1;
    @(negedge clk);
    fillStart = 1'b0;
  endtask

  task automatic sweep();
    for (int v = 0; v < 5; v++) begin
      for (int u = 0; u < 26; u++) begin
        lkEn = 1'b1; lkU = 6'(u); lkV = 3'(v);
        @(negedge clk);
      end
    end
    lkU = 6'd31; lkV = 3'd7;   // R8 far corner
    @(negedge clk);
    lkU = 6'd5; lkV = 3'd6;    // R8 row only
    @(negedge clk);
    lkEn = 1'b0;
    @(negedge clk);
    lanesDone = 1'b1;          // R6 release
    @(negedge clk);
    lanesDone = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(ready), 0);
    chk("R1 burstReq", int'(burstReq), 0);
    chk("R1 lkData", int'(lkData), 0);
    chk("R1 lkErr", int'(lkErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1;
    // R5: stray words while idle must not reach the buffer
    spurious = 1;
    repeat (4) @(negedge clk);
    spurious = 0;
    // interior window
    fill(pack4(10, 30, 12, 28), pack4(5, 7, 6, 8), 1);
    sweep();
    // negative corners clamp to zero (R2)
    fill(pack4(-5, 10, -3, 8), pack4(-2, 1, 0, 2), 0);
    sweep();
    // past far edges clamp to COLS-24, ROWS-4 (R2)
    fill(pack4(50, 60, 55, 58), pack4(29, 30, 31, 29), 0);
    sweep();
    cmpOn = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule